// File: doc/BRIEF.md
# Sticky Load Dependence Steering

This block decides, for each decoded load, which load queue it goes to. A table of one-bit predictions, indexed by bits of the load's PC, says whether the load is expected to alias with an in-flight store. Loads expected to alias go to the associative load queue. Loads expected not to alias go to one bank of the banked non-associative load queue. When every bank is full, such a load falls back to the associative queue.

The table starts with every entry set to independent. A training port sets a single entry to dependent. No path clears an entry again, so the table needs no counters and no decay. A training write and a lookup of the same entry in the same cycle see the new value.

The queues report their occupancy through full flags. The block answers in the same cycle with a grant, the target queue, a bank number and a stall flag. Banks are chosen round-robin, and full banks are skipped.

Top module: `load_dep_steer`

## Requirements
- R1: After reset, every table entry predicts independent (predDep = 0), and the round-robin pointer points at bank 0.
- R2: When trainValid is high, the entry selected by trainPc becomes dependent from the next cycle on. Training one entry leaves every other entry unchanged, and an entry that is dependent stays dependent until reset.
- R3: A lookup whose index equals the training index in the same cycle reports dependent in that cycle.
- R4: A load predicted dependent is granted to the associative queue (allocAssoc = 1, allocBank = 0) whenever assocFull is low.
- R5: A load predicted independent is granted to a bank of the non-associative queue (allocAssoc = 0, allocBank = bank number) when at least one bank is not full.
- R6: A load predicted independent is granted to the associative queue when every bit of bankFull is high and assocFull is low.
- R7: stall is high, and allocValid is low, when the load cannot be placed: it is predicted dependent and assocFull is high, or it is predicted independent and every bank and the associative queue are full. A dependent load stalls even when banks are free.
- R8: Successive bank grants cycle through banks 0, 1, 2, then wrap back to 0, when no bank is full.
- R9: A bank grant starts its search at the round-robin pointer and takes the first bank, in rising order with wraparound, whose bankFull bit is low.
- R10: The round-robin pointer moves only on a bank grant, to the bank after the one granted. It stays put on a stall, on an associative grant and on an idle cycle.
- R11: The table index is loadPc[IDX_W+1:2] (IDX_W = 6 by default). PCs that differ only outside those bits share an entry.
- R12: With loadValid low, allocValid and stall are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | A decoded load asks for a queue slot |
| loadPc | input | PC_W | PC of that load |
| trainValid | input | 1 | Mark the entry of trainPc dependent |
| trainPc | input | PC_W | PC of the load being trained |
| assocFull | input | 1 | Associative queue has no free slot |
| bankFull | input | NBANKS | Per-bank full flags of the non-associative queue |
| predDep | output | 1 | Prediction for loadPc (1 = dependent) |
| allocValid | output | 1 | Load is granted a slot this cycle |
| allocAssoc | output | 1 | Grant targets the associative queue |
| allocBank | output | BANK_W | Granted bank (0 when the grant targets the associative queue) |
| stall | output | 1 | Load cannot be placed this cycle |

## Verification
A table entry that is wrongly cleared or never set shows up on the next lookup of that PC. The load then appears as a bank grant where an associative grant was expected, or the reverse. Because the outputs are combinational on the table state, the error is visible in the very cycle the entry is read. A round-robin pointer that moves when it should not, or lands on the wrong bank, changes allocBank on the next independent grant. For this reason the stimulus follows stalls and associative grants with bank grants and checks the bank number each time. Aliasing PCs and same-cycle training are driven so that an index or bypass error appears at predDep in that same cycle.

// File: rtl/ldsteer_pkg.sv
package ldsteer_pkg;

  // Where a decoded load is sent this cycle.
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_ASSOC = 2'd1,
    TGT_BANK  = 2'd2
  } steerTarget_e;

  // Strobes from the control into the datapath.
  typedef struct packed {
    logic tblWrEn;    // set the trained entry to dependent
    logic rrAdvance;  // move the bank pointer past the granted bank
  } steerStrobe_t;

endpackage

// File: rtl/ldsteer_dpath.sv
module ldsteer_dpath
  import ldsteer_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int NBANKS = 3,
  parameter int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerStrobe_t      strobe,
  input  logic [PC_W-1:0]   loadPc,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [BANK_W-1:0] grantBank,
  output logic              predDep,
  output logic [BANK_W-1:0] rrPtr
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NBANKS - 1);

  logic [ENTRIES-1:0] tbl;
  logic [IDX_W-1:0]   loadIdx;
  logic [IDX_W-1:0]   trainIdx;
  logic               sameIdx;

  // Loads are word aligned, so the two lowest PC bits carry no information.
  assign loadIdx  = loadPc[IDX_W+1:2];
  assign trainIdx = trainPc[IDX_W+1:2];
  assign sameIdx  = strobe.tblWrEn && (trainIdx == loadIdx);

  // Sticky prediction table: bits are only ever set, and reset clears them all.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tbl <= '0;
    end else if (strobe.tblWrEn) begin
      tbl[trainIdx] <= 1'b1;
    end
  end

  // A training write in the same cycle wins over the stored value.
  assign predDep = tbl[loadIdx] | sameIdx;

  // Round-robin bank pointer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.rrAdvance) begin
      rrPtr <= (grantBank == LAST_BANK) ? '0 : grantBank + 1'b1;
    end
  end

  // No entry ever goes from dependent back to independent while out of reset.
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (($past(tbl) & ~tbl) == '0))
    else $error("table entry was cleared");

  // A training write is visible in the table on the following cycle.
  assert_train_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tblWrEn |=> tbl[$past(trainIdx)])
    else $error("trained entry not set");

  // The pointer only ever names an existing bank.
  assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rrPtr <= LAST_BANK))
    else $error("bank pointer out of range");

endmodule

// File: rtl/ldsteer_ctrl.sv
module ldsteer_ctrl
  import ldsteer_pkg::*;
#(
  parameter int NBANKS = 3,
  parameter int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic              trainValid,
  input  logic              predDep,
  input  logic              assocFull,
  input  logic [NBANKS-1:0] bankFull,
  input  logic [BANK_W-1:0] rrPtr,
  output steerStrobe_t      strobe,
  output logic              allocValid,
  output logic              allocAssoc,
  output logic [BANK_W-1:0] allocBank,
  output logic              stall
);

  steerTarget_e      target;
  logic              bankFound;
  logic [BANK_W-1:0] bankPick;
  int                cand;

  // First bank with room, searching upward from the pointer with wraparound.
  always_comb begin
    bankFound = 1'b0;
    bankPick  = '0;
    cand      = 0;
    for (int k = 0; k < NBANKS; k++) begin
      cand = int'(rrPtr) + k;
      if (cand >= NBANKS) cand = cand - NBANKS;
      if (!bankFound && !bankFull[BANK_W'(cand)]) begin
        bankFound = 1'b1;
        bankPick  = BANK_W'(cand);
      end
    end
  end

  // Steering decision.
  always_comb begin
    target = TGT_NONE;
    if (loadValid) begin
      if (predDep) begin
        target = assocFull ? TGT_NONE : TGT_ASSOC;
      end else if (bankFound) begin
        target = TGT_BANK;
      end else if (!assocFull) begin
        target = TGT_ASSOC;
      end
    end
  end

  assign allocValid = (target != TGT_NONE);
  assign allocAssoc = (target == TGT_ASSOC);
  assign allocBank  = (target == TGT_BANK) ? bankPick : '0;
  assign stall      = loadValid && (target == TGT_NONE);

  always_comb begin
    strobe           = '0;
    strobe.tblWrEn   = trainValid;
    strobe.rrAdvance = (target == TGT_BANK);
  end

  assert_dep_to_assoc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && predDep && !assocFull) |-> (allocValid && allocAssoc))
    else $error("dependent load not sent to associative queue");

  assert_bank_has_room_R9: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !allocAssoc) |-> !bankFull[allocBank])
    else $error("grant to a full bank");

  assert_stall_no_grant_R7: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !allocValid)
    else $error("stall together with grant");

  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!allocValid || allocAssoc) |=> $stable(rrPtr))
    else $error("bank pointer moved without a bank grant");

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> (!allocValid && !stall))
    else $error("activity without a load");

endmodule

// File: rtl/load_dep_steer.sv
module load_dep_steer
  import ldsteer_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int NBANKS = 3,
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [PC_W-1:0]   loadPc,
  input  logic              trainValid,
  input  logic [PC_W-1:0]   trainPc,
  input  logic              assocFull,
  input  logic [NBANKS-1:0] bankFull,
  output logic              predDep,
  output logic              allocValid,
  output logic              allocAssoc,
  output logic [BANK_W-1:0] allocBank,
  output logic              stall
);

  steerStrobe_t      strobe;
  logic [BANK_W-1:0] rrPtr;

  ldsteer_ctrl #(
    .NBANKS (NBANKS),
    .BANK_W (BANK_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadValid  (loadValid),
    .trainValid (trainValid),
    .predDep    (predDep),
    .assocFull  (assocFull),
    .bankFull   (bankFull),
    .rrPtr      (rrPtr),
    .strobe     (strobe),
    .allocValid (allocValid),
    .allocAssoc (allocAssoc),
    .allocBank  (allocBank),
    .stall      (stall)
  );

  ldsteer_dpath #(
    .PC_W   (PC_W),
    .IDX_W  (IDX_W),
    .NBANKS (NBANKS),
    .BANK_W (BANK_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadPc    (loadPc),
    .trainPc   (trainPc),
    .grantBank (allocBank),
    .predDep   (predDep),
    .rrPtr     (rrPtr)
  );

endmodule

// File: tb/load_dep_steer_bench.sv
`timescale 1ns/1ps
module load_dep_steer_bench;

  localparam int PC_W = 32;

  // Index bits are PC[7:2]: A -> 1, B -> 2, C -> 3, ALIAS -> 1.
  localparam logic [31:0] PCA  = 32'h0000_1004;
  localparam logic [31:0] PCB  = 32'h0000_2008;
  localparam logic [31:0] PCC  = 32'h0000_100C;
  localparam logic [31:0] PCAL = 32'h0000_1104;

  typedef struct packed {
    logic        lv;
    logic [31:0] lpc;
    logic        tv;
    logic [31:0] tpc;
    logic        af;
    logic [2:0]  bf;
    logic        eV;
    logic        eA;
    logic [1:0]  eBank;
    logic        eSt;
    logic        eDep;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, PCA,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R5"},  // ptr 0 -> 1
    '{1'b1, PCB,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, "R8"},  // -> 2
    '{1'b1, PCC,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, "R8"},  // -> 0
    '{1'b1, PCA,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R8"},  // wrap, -> 1
    '{1'b1, PCA,   1'b0, 32'h0, 1'b0, 3'b010, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, "R9"},  // skip 1, -> 0
    '{1'b1, PCA,   1'b0, 32'h0, 1'b0, 3'b001, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, "R9"},  // skip 0, -> 2
    '{1'b1, PCA,   1'b0, 32'h0, 1'b0, 3'b111, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, "R6"},  // fallback
    '{1'b1, PCA,   1'b0, 32'h0, 1'b1, 3'b111, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, "R7"},  // all full
    '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 3'b000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, "R12"}, // idle
    '{1'b1, PCB,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, "R10"}, // ptr held at 2
    '{1'b1, PCA,   1'b1, PCA,   1'b0, 3'b000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, "R3"},  // same-cycle train
    '{1'b1, PCA,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, "R2"},
    '{1'b1, PCAL,  1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, "R11"}, // alias
    '{1'b1, PCA,   1'b0, 32'h0, 1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, "R7"},  // dep, assoc full
    '{1'b1, PCC,   1'b1, PCB,   1'b0, 3'b000, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R2"},  // other entry, -> 1
    '{1'b1, PCA,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, "R2"},  // still dep
    '{1'b1, PCB,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, "R4"},
    '{1'b1, PCC,   1'b0, 32'h0, 1'b0, 3'b000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, "R10"}  // ptr was 1
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            loadValid = 1'b0;
  logic [PC_W-1:0] loadPc = '0;
  logic            trainValid = 1'b0;
  logic [PC_W-1:0] trainPc = '0;
  logic            assocFull = 1'b0;
  logic [2:0]      bankFull = '0;
  logic            predDep, allocValid, allocAssoc, stall;
  logic [1:0]      allocBank;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  load_dep_steer u_load_dep_steer (
    .clk        (clk),
    .rstN       (rstN),
    .loadValid  (loadValid),
    .loadPc     (loadPc),
    .trainValid (trainValid),
    .trainPc    (trainPc),
    .assocFull  (assocFull),
    .bankFull   (bankFull),
    .predDep    (predDep),
    .allocValid (allocValid),
    .allocAssoc (allocAssoc),
    .allocBank  (allocBank),
    .stall      (stall)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic eV, input logic eA,
                        input logic [1:0] eBank, input logic eSt, input logic eDep);
    chk(req, "predDep",    int'(predDep),    int'(eDep));
    chk(req, "allocValid", int'(allocValid), int'(eV));
    chk(req, "allocAssoc", int'(allocAssoc), int'(eA));
    chk(req, "allocBank",  int'(allocBank),  int'(eBank));
    chk(req, "stall",      int'(stall),      int'(eSt));
  endtask

  task automatic drive(input logic lv, input logic [31:0] lpc, input logic tv,
                       input logic [31:0] tpc, input logic af, input logic [2:0] bf);
    loadValid = lv; loadPc = lpc; trainValid = tv; trainPc = tpc;
    assocFull = af; bankFull = bf;
  endtask

  initial begin
    // R1: reset state seen while reset is held (state cannot change then).
    @(negedge clk);
    drive(1'b1, PCC, 1'b0, 32'h0, 1'b0, 3'b000);
    #1;
    chkAll("R1", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 3'b000);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table walk: drive away from the edge, compare before the next edge.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].lv, VECS[i].lpc, VECS[i].tv, VECS[i].tpc, VECS[i].af, VECS[i].bf);
      #1;
      chkAll($sformatf("%s(vec %0d)", VECS[i].tag, i),
             VECS[i].eV, VECS[i].eA, VECS[i].eBank, VECS[i].eSt, VECS[i].eDep);
    end

    // R7: a dependent load stalls on a full associative queue even with every bank free.
    @(negedge clk);
    drive(1'b1, PCB, 1'b0, 32'h0, 1'b1, 3'b000);
    #1;
    chkAll("R7", 1'b0, 1'b0, 2'd0, 1'b1, 1'b1);

    // R1: reset again clears trained entries and the pointer (pointer was 2).
    @(negedge clk);
    drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 3'b000);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b1, PCA, 1'b0, 32'h0, 1'b0, 3'b000);
    #1;
    chkAll("R1", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b1, PCB, 1'b0, 32'h0, 1'b0, 3'b000);
    #1;
    chkAll("R1", 1'b1, 1'b0, 2'd1, 1'b0, 1'b0);

    // R9: only the last bank has room, pointer at 2 -> bank 2; then pointer wraps to 0.
    @(negedge clk);
    drive(1'b1, PCC, 1'b0, 32'h0, 1'b0, 3'b011);
    #1;
    chkAll("R9", 1'b1, 1'b0, 2'd2, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b1, PCC, 1'b0, 32'h0, 1'b0, 3'b000);
    #1;
    chkAll("R8", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);

    @(negedge clk);
    drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 3'b000);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule